// File: doc/BRIEF.md
# Detection integrator with drift tracking

This block decides whether a proximity or touch signal is present. Once per acquisition burst it takes one 16-bit sample and compares it with a tracked reference level. A trip level lies a programmable distance above the reference, and a release level lies a further hysteresis margin below the trip level. Both move with the reference. A detection is declared only after a programmable run of back-to-back bursts all land above the trip level. It is withdrawn when a burst falls below the release level.

While nothing is detected, the reference creeps toward the signal one count at a time. Upward and downward creep have separate rate settings. A rate setting of N gives one step per N+1 qualifying bursts; for example, a setting of 9 with bursts every 100 ms gives one step per second. Creep stops entirely while a detection is active, so a held object does not become the new baseline.

An active-low recalibration input lets the surrounding logic re-baseline on demand. If the input is held low across enough bursts, then on its return high the reference is loaded with the most recent sample and the detection state is cleared.

Top module: `det_integrator`

## Requirements
- R1: After synchronous reset, `detect` is 0 and `reference` is 0.
- R2: A burst is over-threshold when `sample > reference + threshold`, evaluated without wrap. `detect` goes to 1 on the burst that completes `confirm_target` consecutive over-threshold bursts, and is visible after that burst's clock edge. A target of 0 behaves as 1.
- R3: While `detect` is 0, a burst that is not over-threshold resets the consecutive-burst run to zero.
- R4: While `detect` is 1, a burst with `sample < reference + threshold - hysteresis` (signed, no wrap) clears `detect`. Any other burst leaves it at 1.
- R5: On each burst taken while `detect` is 0 with `sample > reference`, an upward timer advances. The `up_rate + 1`-th such burst raises `reference` by 1 and restarts the timer. A burst with `sample <= reference` restarts the upward timer.
- R6: Downward creep mirrors R5. Bursts with `sample < reference` are counted against `down_rate`, which is set independently of `up_rate`. A burst with `sample >= reference` restarts the downward timer.
- R7: A burst taken while `detect` is 1, or any cycle without a burst, leaves `reference` unchanged.
- R8: If `cal_n` saw at least `CAL_MIN_BURSTS` burst strobes while low, then on the clock edge where it is first seen high again, `reference` takes the latest sample and `detect`, the run count and both drift timers clear. A burst strobe in that same cycle is dropped.
- R9: A return of `cal_n` to high after fewer than `CAL_MIN_BURSTS` strobes while low causes no reload: `reference` and `detect` continue as if the pulse had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_valid | input | 1 | One-cycle strobe: `sample` holds a new burst result |
| sample | input | 16 | Burst signal value |
| threshold | input | 16 | Trip distance above the reference |
| hysteresis | input | 16 | Release margin below the trip level |
| confirm_target | input | 8 | Consecutive over-threshold bursts needed to detect |
| up_rate | input | 8 | Upward drift setting (step every up_rate+1 bursts) |
| down_rate | input | 8 | Downward drift setting (step every down_rate+1 bursts) |
| cal_n | input | 1 | Active-low recalibration request |
| detect | output | 1 | Registered detection flag |
| reference | output | 16 | Registered tracked reference |

## Verification
The bench builds the block with `CAL_MIN_BURSTS` set to 2, so that a one-burst low pulse falls short and a two-burst pulse qualifies. Both sides of R8 and R9 can therefore be exercised in a few cycles. It drives rate settings of 2 upward and 4 downward, which makes drift steps, and the way an opposite-direction burst restarts a timer, visible within a handful of bursts. A confirmation target of 3 lets a broken run be shown to restart the count. The 100-count threshold with 30 counts of hysteresis leaves room for samples that hold a detection and samples that release it.

// File: rtl/det_pkg.sv
package det_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } drift_dir_e;

  function automatic drift_dir_e pick_dir(input logic above, input logic below);
    if (above)      return DIR_UP;
    else if (below) return DIR_DOWN;
    else            return DIR_HOLD;
  endfunction
endpackage

// File: rtl/recal_qualifier.sv
module recal_qualifier #(
  parameter int DATA_W         = 16,
  parameter int CAL_MIN_BURSTS = 1,
  parameter int LOWCNT_W       = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_n,
  input  logic              burst_valid,
  input  logic [DATA_W-1:0] sample,
  output logic              reload,
  output logic [DATA_W-1:0] latest
);
  localparam logic [LOWCNT_W-1:0] LOW_MAX  = '1;
  localparam logic [LOWCNT_W-1:0] LOW_NEED = LOWCNT_W'(CAL_MIN_BURSTS);

  logic                cal_q;
  logic [LOWCNT_W-1:0] low_cnt;

  always_comb reload = cal_n && !cal_q && (low_cnt >= LOW_NEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q   <= 1'b1;
      low_cnt <= '0;
      latest  <= '0;
    end else begin
      cal_q <= cal_n;
      if (!cal_n) begin
        if (burst_valid && low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
      if (burst_valid && !reload) latest <= sample;
    end
  end
endmodule

// File: rtl/burst_confirm.sv
module burst_confirm #(
  parameter int DATA_W = 16,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] reference,
  input  logic [DATA_W-1:0] threshold,
  input  logic [DATA_W-1:0] hysteresis,
  input  logic [RUN_W-1:0]  target,
  input  logic              reload,
  output logic              over,
  output logic              detect
);
  localparam int SUM_W = DATA_W + 2;

  logic signed [SUM_W-1:0] smp_x, trip_lvl, rel_lvl;
  logic                    below_rel;
  logic [RUN_W-1:0]        run_cnt, target_eff;
  logic [RUN_W:0]          run_next;

  always_comb begin
    smp_x      = $signed({2'b00, sample});
    trip_lvl   = $signed({2'b00, reference}) + $signed({2'b00, threshold});
    rel_lvl    = trip_lvl - $signed({2'b00, hysteresis});
    over       = smp_x > trip_lvl;
    below_rel  = smp_x < rel_lvl;
    target_eff = (target == '0) ? RUN_W'(1) : target;
    run_next   = {1'b0, run_cnt} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      detect  <= 1'b0;
      run_cnt <= '0;
    end else if (burst_valid) begin
      if (!detect) begin
        if (over) begin
          if (run_next >= {1'b0, target_eff}) begin
            detect  <= 1'b1;
            run_cnt <= '0;
          end else begin
            run_cnt <= run_next[RUN_W-1:0];
          end
        end else begin
          run_cnt <= '0;
        end
      end else if (below_rel) begin
        detect  <= 1'b0;
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/drift_tracker.sv
module drift_tracker
  import det_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic              detect,
  input  logic [RATE_W-1:0] up_rate,
  input  logic [RATE_W-1:0] down_rate,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_value,
  output logic [DATA_W-1:0] reference
);
  localparam logic [DATA_W-1:0] REF_TOP = '1;
  localparam logic [DATA_W-1:0] REF_BOT = '0;

  logic [RATE_W-1:0] up_cnt, dn_cnt;
  drift_dir_e        dir;

  always_comb dir = pick_dir(sample > reference, sample < reference);

  always_ff @(posedge clk) begin
    if (rst) begin
      reference <= '0;
      up_cnt    <= '0;
      dn_cnt    <= '0;
    end else if (reload) begin
      reference <= reload_value;
      up_cnt    <= '0;
      dn_cnt    <= '0;
    end else if (burst_valid && !detect) begin
      case (dir)
        DIR_UP: begin
          dn_cnt <= '0;
          if (up_cnt == up_rate) begin
            up_cnt <= '0;
            if (reference != REF_TOP) reference <= reference + 1'b1;
          end else begin
            up_cnt <= up_cnt + 1'b1;
          end
        end
        DIR_DOWN: begin
          up_cnt <= '0;
          if (dn_cnt == down_rate) begin
            dn_cnt <= '0;
            if (reference != REF_BOT) reference <= reference - 1'b1;
          end else begin
            dn_cnt <= dn_cnt + 1'b1;
          end
        end
        default: begin
          up_cnt <= '0;
          dn_cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/det_integrator.sv
module det_integrator #(
  parameter int DATA_W         = 16,
  parameter int RATE_W         = 8,
  parameter int RUN_W          = 8,
  parameter int CAL_MIN_BURSTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] threshold,
  input  logic [DATA_W-1:0] hysteresis,
  input  logic [RUN_W-1:0]  confirm_target,
  input  logic [RATE_W-1:0] up_rate,
  input  logic [RATE_W-1:0] down_rate,
  input  logic              cal_n,
  output logic              detect,
  output logic [DATA_W-1:0] reference
);
  localparam int LOWCNT_W = (CAL_MIN_BURSTS < 1) ? 1 : $clog2(CAL_MIN_BURSTS + 1);

  logic              reload;
  logic              over_thr;
  logic [DATA_W-1:0] latest;

  recal_qualifier #(
    .DATA_W(DATA_W), .CAL_MIN_BURSTS(CAL_MIN_BURSTS), .LOWCNT_W(LOWCNT_W)
  ) u_recal (
    .clk(clk), .rst(rst), .cal_n(cal_n), .burst_valid(burst_valid),
    .sample(sample), .reload(reload), .latest(latest)
  );

  burst_confirm #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_confirm (
    .clk(clk), .rst(rst), .burst_valid(burst_valid), .sample(sample),
    .reference(reference), .threshold(threshold), .hysteresis(hysteresis),
    .target(confirm_target), .reload(reload), .over(over_thr), .detect(detect)
  );

  drift_tracker #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_drift (
    .clk(clk), .rst(rst), .burst_valid(burst_valid), .sample(sample),
    .detect(detect), .up_rate(up_rate), .down_rate(down_rate),
    .reload(reload), .reload_value(latest), .reference(reference)
  );
endmodule

// File: rtl/det_integrator_chk.sv
module det_integrator_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              burst_valid,
  input logic              cal_n,
  input logic              reload,
  input logic              over_thr,
  input logic [DATA_W-1:0] latest,
  input logic              detect,
  input logic [DATA_W-1:0] reference
);
  // R2: a new detection needs an accepted over-threshold burst
  a_r2_rise_needs_over: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> $past(burst_valid && over_thr && !reload));

  // R4: detection ends only through a burst that is not over, or a reload
  a_r4_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(detect) |-> $past(reload || (burst_valid && !over_thr)));

  // R5: creep moves the reference by at most one count per burst
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    (!reload && burst_valid && !detect) |=>
      (reference == $past(reference) ||
       reference == $past(reference) + 1'b1 ||
       reference == $past(reference) - 1'b1));

  // R7: frozen reference while detecting or between bursts
  a_r7_no_drift_when_detected: assert property (@(posedge clk) disable iff (rst)
    (!reload && (detect || !burst_valid)) |=> $stable(reference));

  // R8: a reload takes the latest sample and clears detection
  a_r8_reload_loads: assert property (@(posedge clk) disable iff (rst)
    reload |=> (!detect && reference == $past(latest)));

  // R9: reload only on the first high cycle of cal_n
  a_r9_reload_on_release: assert property (@(posedge clk) disable iff (rst)
    reload |-> (cal_n && !$past(cal_n)));
endmodule

bind det_integrator det_integrator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .burst_valid(burst_valid), .cal_n(cal_n),
  .reload(reload), .over_thr(over_thr), .latest(latest),
  .detect(detect), .reference(reference)
);

// File: tb/det_integrator_bench.sv
`timescale 1ns/1ps
module det_integrator_bench;
  localparam int CAL_MIN = 2;
  localparam int THR = 100, HYS = 30, TGT = 3, UPR = 2, DNR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_valid = 1'b0;
  logic [15:0] sample = '0;
  logic        cal_n = 1'b1;
  logic        detect;
  logic [15:0] reference;

  always #2.5 clk = ~clk;

  det_integrator #(.DATA_W(16), .RATE_W(8), .RUN_W(8), .CAL_MIN_BURSTS(CAL_MIN)) u_det_integrator (
    .clk(clk), .rst(rst), .burst_valid(burst_valid), .sample(sample),
    .threshold(16'(THR)), .hysteresis(16'(HYS)), .confirm_target(8'(TGT)),
    .up_rate(8'(UPR)), .down_rate(8'(DNR)), .cal_n(cal_n),
    .detect(detect), .reference(reference)
  );

  typedef struct {
    logic  det;
    int    refv;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int m_ref = 0, m_run = 0, m_up = 0, m_dn = 0, m_last = 0, m_low = 0;
  bit m_det = 0, m_cal_low = 0;

  task automatic model_burst(input int s);
    if (m_cal_low) m_low++;
    m_last = s;
    if (!m_det) begin
      if (s > m_ref + THR) begin
        m_run++;
        if (m_run >= ((TGT == 0) ? 1 : TGT)) begin m_det = 1; m_run = 0; end
      end else m_run = 0;
      if (s > m_ref) begin
        m_dn = 0; m_up++;
        if (m_up > UPR) begin m_up = 0; if (m_ref < 65535) m_ref++; end
      end else if (s < m_ref) begin
        m_up = 0; m_dn++;
        if (m_dn > DNR) begin m_dn = 0; if (m_ref > 0) m_ref--; end
      end else begin m_up = 0; m_dn = 0; end
    end else if (s < m_ref + THR - HYS) begin
      m_det = 0; m_run = 0;
    end
  endtask

  task automatic push(input string req);
    exp_t e;
    e.det = m_det; e.refv = m_ref; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drive_burst(input int s, input string req);
    @(negedge clk);
    model_burst(s);
    push(req);
    sample = 16'(s);
    burst_valid = 1'b1;
    @(negedge clk);
    burst_valid = 1'b0;
  endtask

  task automatic cal_low();
    @(negedge clk);
    cal_n = 1'b0;
    m_cal_low = 1; m_low = 0;
  endtask

  task automatic cal_release(input string req);
    @(negedge clk);
    cal_n = 1'b1;
    m_cal_low = 0;
    if (m_low >= CAL_MIN) begin
      m_ref = m_last; m_det = 0; m_run = 0; m_up = 0; m_dn = 0;
    end
    push(req);
    @(negedge clk);
  endtask

  // monitor: compares one expected item per burst or release cycle
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (detect !== e.det || int'(reference) != e.refv) begin
        failures++;
        $display("FAIL %s: detect=%0b reference=%0d expected detect=%0b reference=%0d",
                 e.req, detect, reference, e.det, e.refv);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (detect !== 1'b0) begin failures++; $display("FAIL R1: detect=%0b expected 0", detect); end
    checks++;
    if (reference !== 16'd0) begin failures++; $display("FAIL R1: reference=%0d expected 0", reference); end

    // R8 qualifying recalibration pulse
    cal_low();
    drive_burst(1000, "R8");
    drive_burst(1000, "R8");
    cal_release("R8");

    // R5 upward creep, timer restarted by a lower burst
    repeat (3) drive_burst(1050, "R5");
    drive_burst(990, "R5");
    repeat (3) drive_burst(1050, "R5");

    // R6 downward creep at its own rate
    repeat (5) drive_burst(900, "R6");

    // R3 broken run restarts, then R2 full run detects
    drive_burst(1200, "R3");
    drive_burst(1200, "R3");
    drive_burst(1050, "R3");
    drive_burst(1200, "R3");
    drive_burst(1200, "R3");
    drive_burst(1200, "R2");

    // R7 frozen reference and R4 hold above release level
    repeat (4) drive_burst(1100, "R7");
    drive_burst(1060, "R4");

    // R9 short pulse does not reload
    cal_low();
    drive_burst(1060, "R9");
    cal_release("R9");
    drive_burst(1060, "R9");

    // R2 detect again, then R8 recalibration clears it
    repeat (3) drive_burst(1300, "R2");
    cal_low();
    drive_burst(1300, "R8");
    drive_burst(1300, "R8");
    cal_release("R8");
    drive_burst(1300, "R8");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule